// File: doc/BRIEF.md
# Transport Packet Staging Buffer

This block accepts transport-stream packets one byte per cycle and stores each one in a RAM slot together with the destination channel it belongs to. It holds them there until the external-memory arbiter allows a write. Packets are accepted only whole. A packet becomes visible to the arbiter once all 192 of its bytes are in. When no slot is free, the block pushes back on the source.

On the output side the block presents a write request together with the channel tag of the oldest complete packet, so that an address mapper can turn the tag into a memory location before the grant. After the grant arrives, the whole packet leaves as one unbroken burst of 192 bytes, and its slot returns to the free pool. A packet that is cut short, because a new start-of-packet arrives before byte 192, is dropped and reported on an error pulse.

Top module: `pkt_stage_buf`

## Requirements
- R1: After reset, `in_ready` is 1 and `wr_req`, `out_valid`, `out_last`, `err_short` and `buf_full` are all 0.
- R2: A packet is a beat with `in_sop`=1 (its channel taken from `in_chan` on that beat only) followed by 191 beats with `in_sop`=0. In the cycle after the edge that accepts its 192nd byte, `wr_req` is 1 when no burst is running, and `wr_chan` then shows that packet's channel. Both hold until a grant.
- R3: When `wr_req` and `wr_grant` are both 1 at a clock edge, `out_valid` is 1 for exactly the next 192 consecutive cycles. `out_data` carries the packet bytes in the order they were received, and `out_chan` carries its channel.
- R4: `out_last` is 1 on the 192nd beat of a burst and 0 on all other beats.
- R5: Complete packets are offered to the arbiter in the order they completed, whichever slots they occupy.
- R6: When every slot holds a packet and none is being filled, `buf_full` is 1 and `in_ready` is 0. The slot of a sent packet is free again in the cycle that shows `out_last`.
- R7: An `in_sop` beat that arrives while a packet is incomplete produces a one-cycle `err_short` pulse in the following cycle. The partial packet is never offered. The new beat starts a fresh packet.
- R8: Beats with `in_sop`=0 that arrive while no packet is being filled are ignored and never show up in any output burst.
- R9: `wr_grant` has no effect while `wr_req` is 0.
- R10: `wr_req` is 0 during a burst. If another packet is complete, `wr_req` returns in the cycle that shows `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | DATA_W | Input byte |
| in_chan | input | CH_W | Destination channel, sampled on the start beat |
| in_ready | output | 1 | Input byte will be accepted |
| buf_full | output | 1 | No free slot |
| err_short | output | 1 | Pulse: a truncated packet was dropped |
| wr_req | output | 1 | A complete packet waits for the write path |
| wr_chan | output | CH_W | Channel of the waiting packet |
| wr_grant | input | 1 | Arbiter write permit |
| out_valid | output | 1 | Burst byte valid |
| out_data | output | DATA_W | Burst byte |
| out_last | output | 1 | Final byte of the burst |
| out_chan | output | CH_W | Channel of the packet being sent |

## Verification
The results fall due at three latencies. `wr_req` and `wr_chan` follow one cycle after the edge that takes in the final byte. The first burst byte follows one cycle after the grant edge, and each later byte comes one cycle after the one before it. `err_short` follows one cycle after the start beat that cuts a packet short. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which is half a period after the edge that produced them. Each check therefore expects exactly one register stage per edge. During a burst, beat k is compared in the k-th cycle after the grant against a byte value computed from the packet number and the byte index.

// File: rtl/pkt_stage_pkg.sv
package pkt_stage_pkg;
  localparam int TS_PKT_BYTES = 192;
  localparam int TS_DATA_W    = 8;
  localparam int TS_CH_W      = 9;

  typedef enum logic {
    BURST_IDLE = 1'b0,
    BURST_RUN  = 1'b1
  } burst_state_e;
endpackage

// File: rtl/slot_ram.sv
module slot_ram #(
  parameter int WORDS  = 768,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              release_req,
  input  logic [SLOT_W-1:0] release_slot,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              any_free
);
  logic [NUM_SLOTS-1:0] occ;

  always_comb begin
    alloc_slot = '0;
    any_free   = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        alloc_slot = SLOT_W'(i);
        any_free   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_occ
    always_ff @(posedge clk) begin
      if (rst) begin
        occ[g] <= 1'b0;
      end else if (alloc_req && alloc_slot == SLOT_W'(g)) begin
        occ[g] <= 1'b1;
      end else if (release_req && release_slot == SLOT_W'(g)) begin
        occ[g] <= 1'b0;
      end
    end
  end

  // R6: a slot is only taken when one is free
  a_r6_alloc_needs_free: assert property (@(posedge clk) disable iff (rst)
    alloc_req |-> any_free);
  // R6: only an occupied slot is returned
  a_r6_release_occupied: assert property (@(posedge clk) disable iff (rst)
    release_req |-> occ[release_slot]);
endmodule

// File: rtl/order_queue.sv
module order_queue #(
  parameter int DEPTH  = 4,
  parameter int SLOT_W = 2,
  parameter int CH_W   = 9,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_slot,
  input  logic [CH_W-1:0]   push_chan,
  input  logic              pop,
  output logic              empty,
  output logic [SLOT_W-1:0] head_slot,
  output logic [CH_W-1:0]   head_chan
);
  logic [SLOT_W-1:0] slot_mem [DEPTH];
  logic [CH_W-1:0]   chan_mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              full;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign head_slot = slot_mem[rp];
  assign head_chan = chan_mem[rp];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      slot_mem[wp] <= push_slot;
      chan_mem[wp] <= push_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt <= cnt + CNT_W'(1);
      else if (pop && !push) cnt <= cnt - CNT_W'(1);
    end
  end

  // R5: the arrival-order list never overflows or underflows
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/pkt_stage_buf.sv
module pkt_stage_buf
  import pkt_stage_pkg::*;
#(
  parameter int DATA_W    = TS_DATA_W,
  parameter int CH_W      = TS_CH_W,
  parameter int PKT_BYTES = TS_PKT_BYTES,
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  output logic              in_ready,
  output logic              buf_full,
  output logic              err_short,
  output logic              wr_req,
  output logic [CH_W-1:0]   wr_chan,
  input  logic              wr_grant,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [CH_W-1:0]   out_chan
);
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int BEAT_W    = $clog2(PKT_BYTES + 1);
  localparam int RAM_WORDS = NUM_SLOTS * PKT_BYTES;
  localparam int ADDR_W    = $clog2(RAM_WORDS);

  // fill side state
  logic              filling;
  logic [SLOT_W-1:0] fill_slot;
  logic [BEAT_W-1:0] fill_cnt;
  logic [CH_W-1:0]   fill_chan;

  // drain side state
  burst_state_e      bst;
  logic [BEAT_W-1:0] beat;

  // interconnect
  logic              any_free, alloc_req;
  logic [SLOT_W-1:0] alloc_slot, cur_slot;
  logic              q_empty;
  logic [SLOT_W-1:0] q_slot;
  logic [CH_W-1:0]   q_chan;
  logic              accept, start, cont, restart, publish;
  logic              take, issue, last_issue;
  logic [ADDR_W-1:0] waddr, raddr, woff, roff;

  assign in_ready = filling || any_free;
  assign buf_full = !any_free;

  assign accept    = in_valid && in_ready;
  assign start     = accept && in_sop;
  assign cont      = accept && !in_sop && filling;
  assign restart   = start && filling;
  assign alloc_req = start && !filling;
  assign publish   = cont && (fill_cnt == BEAT_W'(PKT_BYTES - 1));
  assign cur_slot  = filling ? fill_slot : alloc_slot;

  assign woff  = start ? '0 : ADDR_W'(fill_cnt);
  assign waddr = ADDR_W'(cur_slot) * ADDR_W'(PKT_BYTES) + woff;

  always_ff @(posedge clk) begin
    if (rst) begin
      filling   <= 1'b0;
      fill_slot <= '0;
      fill_cnt  <= '0;
      fill_chan <= '0;
      err_short <= 1'b0;
    end else begin
      err_short <= restart;
      if (start) begin
        filling   <= 1'b1;
        fill_slot <= cur_slot;
        fill_cnt  <= BEAT_W'(1);
        fill_chan <= in_chan;
      end else if (cont) begin
        if (publish) begin
          filling  <= 1'b0;
          fill_cnt <= '0;
        end else begin
          fill_cnt <= fill_cnt + BEAT_W'(1);
        end
      end
    end
  end

  // drain side
  assign wr_req     = (bst == BURST_IDLE) && !q_empty;
  assign wr_chan    = q_chan;
  assign take       = wr_req && wr_grant;
  assign issue      = take || (bst == BURST_RUN);
  assign last_issue = (bst == BURST_RUN) && (beat == BEAT_W'(PKT_BYTES));

  assign roff  = take ? '0 : ADDR_W'(beat - BEAT_W'(1));
  assign raddr = ADDR_W'(q_slot) * ADDR_W'(PKT_BYTES) + roff;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst       <= BURST_IDLE;
      beat      <= BEAT_W'(1);
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_chan  <= '0;
    end else begin
      out_valid <= issue;
      out_last  <= last_issue;
      if (take) begin
        bst      <= BURST_RUN;
        beat     <= BEAT_W'(2);
        out_chan <= q_chan;
      end else if (last_issue) begin
        bst  <= BURST_IDLE;
        beat <= BEAT_W'(1);
      end else if (bst == BURST_RUN) begin
        beat <= beat + BEAT_W'(1);
      end
    end
  end

  slot_ram #(.WORDS(RAM_WORDS), .DATA_W(DATA_W)) ram_i (
    .clk   (clk),
    .we    (start || cont),
    .waddr (waddr),
    .wdata (in_data),
    .re    (issue),
    .raddr (raddr),
    .rdata (out_data)
  );

  slot_alloc #(.NUM_SLOTS(NUM_SLOTS)) alloc_i (
    .clk          (clk),
    .rst          (rst),
    .alloc_req    (alloc_req),
    .release_req  (last_issue),
    .release_slot (q_slot),
    .alloc_slot   (alloc_slot),
    .any_free     (any_free)
  );

  order_queue #(.DEPTH(NUM_SLOTS), .SLOT_W(SLOT_W), .CH_W(CH_W)) queue_i (
    .clk       (clk),
    .rst       (rst),
    .push      (publish),
    .push_slot (fill_slot),
    .push_chan (fill_chan),
    .pop       (last_issue),
    .empty     (q_empty),
    .head_slot (q_slot),
    .head_chan (q_chan)
  );

  // R4: the last marker only appears on a valid beat
  a_r4_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R3: a burst is never broken before its last beat
  a_r3_burst_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);
  // R3 and R9: a burst only starts after an accepted grant
  a_r3_start_on_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(wr_req && wr_grant));
  // R10: no new request while a burst is still running
  a_r10_no_req_in_burst: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> !wr_req);
  // R7: the error pulse follows a start beat
  a_r7_err_after_sop: assert property (@(posedge clk) disable iff (rst)
    err_short |-> $past(in_valid && in_sop));
endmodule

// File: tb/pkt_stage_buf_tb.sv
module pkt_stage_buf_tb_top;
  localparam int DW = 8;
  localparam int CW = 9;
  localparam int PB = 192;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_sop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_chan = '0;
  logic          in_ready, buf_full, err_short, wr_req;
  logic [CW-1:0] wr_chan, out_chan;
  logic          wr_grant = 1'b0;
  logic          out_valid, out_last;
  logic [DW-1:0] out_data;

  int vectors = 0;
  int fails   = 0;
  int exp_id [64];
  int exp_head = 0, exp_tail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkt_stage_buf #(.DATA_W(DW), .CH_W(CW), .PKT_BYTES(PB), .NUM_SLOTS(NS)) dut_i (
    .clk, .rst, .in_valid, .in_sop, .in_data, .in_chan, .in_ready, .buf_full,
    .err_short, .wr_req, .wr_chan, .wr_grant, .out_valid, .out_data,
    .out_last, .out_chan
  );

  function automatic logic [DW-1:0] byte_of(input int id, input int i);
    return DW'((id * 37 + i * 5 + 11) & 255);
  endfunction

  function automatic logic [CW-1:0] chan_of(input int id);
    return CW'((id * 77 + 3) % 512);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int id, input int len, output bit err1);
    err1 = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!in_ready) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      if (i == 1) err1 = err_short;
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_data  = byte_of(id, i);
      in_chan  = (i == 0) ? chan_of(id) : CW'(511);
      if (i == PB - 1) begin
        exp_id[exp_tail % 64] = id;
        exp_tail++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic drain_one(input int delay);
    int id;
    @(negedge clk);
    while (!wr_req) @(negedge clk);
    id = exp_id[exp_head % 64];
    chk(wr_chan == chan_of(id), "R2 R5 wr_chan", wr_chan, chan_of(id));
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk(wr_req && wr_chan == chan_of(id), "R2 request hold", wr_chan, chan_of(id));
    end
    wr_grant = 1'b1;
    @(negedge clk);
    wr_grant = 1'b0;
    for (int k = 0; k < PB; k++) begin
      chk(out_valid, "R3 out_valid", out_valid, 1);
      chk(out_data == byte_of(id, k), "R3 R5 out_data", out_data, byte_of(id, k));
      chk(out_last == (k == PB - 1), "R4 out_last", out_last, (k == PB - 1));
      chk(out_chan == chan_of(id), "R3 out_chan", out_chan, chan_of(id));
      if (k < PB - 1) begin
        chk(!wr_req, "R10 req in burst", wr_req, 0);
        @(negedge clk);
      end
    end
    exp_head++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(wr_req == 1'b0, "R1 wr_req", wr_req, 0);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1 out_valid", out_valid, 0);
    chk(err_short == 1'b0, "R1 err_short", err_short, 0);
    chk(buf_full == 1'b0, "R1 buf_full", buf_full, 0);

    // R9 grant without request
    wr_grant = 1'b1;
    @(negedge clk);
    wr_grant = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 grant ignored", out_valid, 0);
    chk(wr_req == 1'b0, "R9 no request", wr_req, 0);

    // R8 stray bytes while idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hEE;
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(wr_req == 1'b0, "R8 stray no request", wr_req, 0);
    chk(buf_full == 1'b0, "R8 stray no slot", buf_full, 0);

    // R2 R3 R4 single packet, stray bytes absent from burst (R8)
    send_pkt(0, PB, e);
    chk(e == 1'b0, "R7 no error on full packet", e, 0);
    chk(wr_req == 1'b1 && wr_chan == chan_of(0), "R2 request after last byte", wr_req, 1);
    drain_one(0);
    @(negedge clk);
    chk(wr_req == 1'b0, "R10 queue empty", wr_req, 0);

    // R6 fill every slot, R5 ordering
    for (int p = 1; p <= NS; p++) send_pkt(p, PB, e);
    chk(buf_full == 1'b1, "R6 buf_full", buf_full, 1);
    chk(in_ready == 1'b0, "R6 in_ready low", in_ready, 0);
    drain_one(2);
    chk(buf_full == 1'b0, "R6 slot freed at last", buf_full, 0);
    chk(in_ready == 1'b1, "R6 in_ready back", in_ready, 1);
    chk(wr_req == 1'b1, "R10 next request at last", wr_req, 1);
    for (int p = 2; p <= NS; p++) drain_one((p * 3) % 7);
    @(negedge clk);
    chk(wr_req == 1'b0, "R5 all drained", wr_req, 0);

    // R7 truncated packet followed by a fresh start
    send_pkt(5, 50, e);
    send_pkt(6, PB, e);
    chk(e == 1'b1, "R7 err_short pulse", e, 1);
    chk(err_short == 1'b0, "R7 pulse is single", err_short, 0);
    drain_one(1);
    repeat (3) @(negedge clk);
    chk(wr_req == 1'b0, "R7 partial not offered", wr_req, 0);

    // R5 concurrent fill and drain with varying grant delays
    fork
      begin
        for (int p = 7; p < 17; p++) send_pkt(p, PB, e);
      end
      begin
        for (int p = 7; p < 17; p++) drain_one((p * 5) % 9);
      end
    join
    repeat (2) @(negedge clk);
    chk(wr_req == 1'b0 && buf_full == 1'b0, "R5 R6 idle at end", wr_req, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule